// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external host read and write a 32-byte internal register file over a serial link with a clock, an active-low select and one or two data lines. Each transaction opens with an 8-bit header, sent most significant bit first. The header holds a direction flag, a two-bit byte count and a 5-bit start address. The host then moves one to four data bytes. After each byte the register address steps down by one, and it wraps from 0 to 31.

Read data leaves on the falling edge of the serial clock, so the host can sample it on the following rising edge. A mode input picks where the read data appears. In 3-wire mode it goes back on the shared data line, which is split here into an input, an output and an output enable. In 4-wire mode it goes out on a separate serial output. The block also owns each output enable, and it drives a line only while read data is actually being moved.

All serial inputs are brought into the system clock domain through synchronizers, and the block detects serial clock edges there. The serial clock must therefore stay high and stay low for at least `SYNC_STAGES + 2` system clocks. A parallel port reads and writes the same register file from the system side.

Top module: `spi_regport`

## Requirements
- R1: After reset every register reads 0 on the parallel port, and both output enables (`sdio_oe`, `sdo_oe`) are low.
- R2: The header is sampled on 8 rising serial clock edges after `sen_n` falls. The bits arrive in this order: direction (0 = write, 1 = read), count bit 1, count bit 0, then address bits 4 down to 0.
- R3: Write data is taken MSB first on the 8 rising edges that follow the header. A byte is stored only once its 8th bit has arrived. If `sen_n` rises earlier, that byte leaves its register unchanged.
- R4: Count value c moves c+1 bytes (00 = 1 up to 11 = 4). Byte j goes to or comes from address (start − j) mod 32.
- R5: In a read, each data bit is driven after a falling serial clock edge, MSB first. The bit is stable at the next rising edge.
- R6: With `mode_3wire` = 1, `sdio_oe` is high through the read data phase, and `sdo_oe` stays low for the whole transaction.
- R7: With `mode_3wire` = 0, `sdo_oe` is high through the read data phase, and `sdio_oe` stays low for the whole transaction.
- R8: Both enables stay low during the header, during write data, and once the byte count is used up. Both return low within 4 system clocks after `sen_n` rises.
- R9: Serial clock edges after the last counted byte, with `sen_n` still low, change no register.
- R10: `par_rdata` shows the register at `par_addr` one system clock later. With `par_we` = 1, `par_wdata` is stored at `par_addr`, and an SPI read then returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_3wire | input | 1 | 1 = read data on the shared line, 0 = on `sdo_o`; captured at transaction start |
| sclk | input | 1 | Serial clock from the host |
| sen_n | input | 1 | Active-low transaction select |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side |
| sdio_oe | output | 1 | Output enable for the shared line |
| sdo_o | output | 1 | Dedicated serial read output |
| sdo_oe | output | 1 | Output enable for `sdo_o` |
| par_addr | input | 5 | Parallel port register address |
| par_we | input | 1 | Parallel write strobe |
| par_wdata | input | 8 | Parallel write data |
| par_rdata | output | 8 | Parallel read data (registered) |

## Verification
A serial edge reaches internal state three system clocks after it appears on the pin: two synchronizer stages and one action register. Each output enable follows one clock after that, and a stored write lands at the same point. The bench holds each half of the serial clock for 8 system clocks and samples the read bit and both enables just before the next rising edge. It checks the register file through the parallel port only after at least 8 further clocks, and checks enable release 6 clocks after `sen_n` rises, so every sample falls well after its result is due.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  localparam int CNT_BITS = 2;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
  parameter int                 STAGES = 2,
  parameter int                 WIDTH  = 4,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_rp_regfile.sv
module spi_rp_regfile #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_we,
  input  logic [AW-1:0] spi_waddr,
  input  logic [DW-1:0] spi_wdata,
  input  logic [AW-1:0] spi_raddr,
  output logic [DW-1:0] spi_rdata,
  input  logic          par_we,
  input  logic [AW-1:0] par_addr,
  input  logic [DW-1:0] par_wdata,
  output logic [DW-1:0] par_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Serial writes win a same-cycle collision with the parallel port.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      par_rdata <= '0;
    end else begin
      if (spi_we)      mem[spi_waddr] <= spi_wdata;
      else if (par_we) mem[par_addr]  <= par_wdata;
      par_rdata <= mem[par_addr];
    end
  end

  assign spi_rdata = mem[spi_raddr];

  a_r10_spi_wins: assert property (@(posedge clk) disable iff (rst)
    (spi_we && par_we) |=> (mem[$past(spi_waddr)] == $past(spi_wdata)));

  a_r10_par_store: assert property (@(posedge clk) disable iff (rst)
    (par_we && !spi_we) |=> (mem[$past(par_addr)] == $past(par_wdata)));
endmodule

// File: rtl/spi_rp_seq.sv
module spi_rp_seq
  import spi_rp_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          sen_n_s,
  input  logic          din_s,
  input  logic          mode3_s,
  input  logic [DW-1:0] rd_byte,
  output logic [AW-1:0] raddr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          dout,
  output logic          sdio_oe,
  output logic          sdo_oe
);
  localparam int HDR_W = 1 + CNT_BITS + AW;
  localparam int MAXW  = max2(HDR_W, DW);
  localparam int BCW   = $clog2(MAXW);
  localparam int SHW   = MAXW - 1;

  phase_t               phase;
  logic                 sclk_q;
  logic                 rise, fall;
  logic [BCW-1:0]       bit_cnt;
  logic [SHW-1:0]       shreg;
  logic                 rw_q;
  logic                 mode3_q;
  logic [CNT_BITS-1:0]  left;
  logic [AW-1:0]        addr_q;
  logic [HDR_W-1:0]     hdr;
  logic [BCW-1:0]       rd_idx;

  assign rise   = sclk_s & ~sclk_q;
  assign fall   = ~sclk_s & sclk_q;
  assign hdr    = {shreg[HDR_W-2:0], din_s};
  assign rd_idx = BCW'(DW - 1) - bit_cnt;
  assign raddr  = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
      rw_q    <= 1'b0;
      mode3_q <= 1'b0;
      left    <= '0;
      addr_q  <= '0;
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
      dout    <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      we     <= 1'b0;
      if (sen_n_s) begin
        phase <= PH_IDLE;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            phase   <= PH_HDR;
            bit_cnt <= '0;
            mode3_q <= mode3_s;
          end
          PH_HDR: if (rise) begin
            shreg <= {shreg[SHW-2:0], din_s};
            if (bit_cnt == BCW'(HDR_W - 1)) begin
              rw_q    <= hdr[HDR_W-1];
              left    <= hdr[HDR_W-2 -: CNT_BITS];
              addr_q  <= hdr[AW-1:0];
              bit_cnt <= '0;
              phase   <= PH_DATA;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (fall && rw_q) dout <= rd_byte[rd_idx];
            if (rise) begin
              shreg <= {shreg[SHW-2:0], din_s};
              if (bit_cnt == BCW'(DW - 1)) begin
                if (!rw_q) begin
                  we    <= 1'b1;
                  waddr <= addr_q;
                  wdata <= {shreg[DW-2:0], din_s};
                end
                addr_q  <= addr_q - 1'b1;
                bit_cnt <= '0;
                if (left == '0) phase <= PH_DONE;
                else            left  <= left - 1'b1;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Output enables: registered from the phase, released as soon as sen_n rises.
  always_ff @(posedge clk) begin
    if (rst) begin
      sdio_oe <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      sdio_oe <= !sen_n_s && (phase == PH_DATA) && rw_q && mode3_q;
      sdo_oe  <= !sen_n_s && (phase == PH_DATA) && rw_q && !mode3_q;
    end
  end

  a_r6_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sdio_oe && sdo_oe));

  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    sen_n_s |=> (!sdio_oe && !sdo_oe));

  a_r8_oe_only_reads: assert property (@(posedge clk) disable iff (rst)
    (sdio_oe || sdo_oe) |-> rw_q);

  a_r3_write_only_in_write: assert property (@(posedge clk) disable iff (rst)
    we |-> !rw_q);

  a_r4_addr_steps_down: assert property (@(posedge clk) disable iff (rst)
    we |-> (addr_q == waddr - 1'b1));

  a_r4_count_nonincreasing: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_DATA) && $past(phase == PH_DATA)) |-> (left <= $past(left)));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_DONE) && $past(phase == PH_DONE)) |-> !we);
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int AW          = 5,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_3wire,
  input  logic          sclk,
  input  logic          sen_n,
  input  logic          sdio_i,
  output logic          sdio_o,
  output logic          sdio_oe,
  output logic          sdo_o,
  output logic          sdo_oe,
  input  logic [AW-1:0] par_addr,
  input  logic          par_we,
  input  logic [DW-1:0] par_wdata,
  output logic [DW-1:0] par_rdata
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, sync_out;
  logic             sclk_s, sen_n_s, din_s, mode3_s;
  logic [DW-1:0]    rd_byte;
  logic [AW-1:0]    raddr, waddr;
  logic [DW-1:0]    wdata;
  logic             we, dout;

  assign raw_in = {mode_3wire, sdio_i, sen_n, sclk};
  assign {mode3_s, din_s, sen_n_s, sclk_s} = sync_out;

  spi_rp_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (NSYNC),
    .RST_VAL(4'b0010)
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  spi_rp_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .sen_n_s(sen_n_s), .din_s(din_s), .mode3_s(mode3_s),
    .rd_byte(rd_byte), .raddr(raddr),
    .we(we), .waddr(waddr), .wdata(wdata),
    .dout(dout), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe)
  );

  spi_rp_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .spi_we(we), .spi_waddr(waddr), .spi_wdata(wdata),
    .spi_raddr(raddr), .spi_rdata(rd_byte),
    .par_we(par_we), .par_addr(par_addr), .par_wdata(par_wdata),
    .par_rdata(par_rdata)
  );

  assign sdio_o = dout;
  assign sdo_o  = dout;
endmodule

// File: tb/tb_spi_regport.sv
`timescale 1ns/1ps
module tb_spi_regport;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_3wire = 1'b0, sclk = 1'b0, sen_n = 1'b1, sdio_i = 1'b0;
  logic       sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [4:0] par_addr = '0;
  logic       par_we = 1'b0;
  logic [7:0] par_wdata = '0;
  logic [7:0] par_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [32];

  always #10 clk = ~clk;

  spi_regport dut (
    .clk(clk), .rst(rst), .mode_3wire(mode_3wire), .sclk(sclk), .sen_n(sen_n),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o),
    .sdo_oe(sdo_oe), .par_addr(par_addr), .par_we(par_we),
    .par_wdata(par_wdata), .par_rdata(par_rdata)
  );

  function automatic logic [4:0] step_addr(input logic [4:0] a, input int j);
    return 5'(a - 5'(j));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial transaction; nbits data bits are clocked after the header.
  task automatic spi_txn(input logic rw, input logic [1:0] cnt, input logic [4:0] a,
                         input logic m3, input logic [31:0] wbytes, input int nbits,
                         output logic [31:0] rbytes, output int oe_err);
    logic [7:0] hdr;
    int counted;
    hdr = {rw, cnt, a};
    counted = 8 * (int'(cnt) + 1);
    rbytes = '0;
    oe_err = 0;
    mode_3wire = m3;
    sen_n = 1'b0;
    wait_clk(HALF);
    for (int i = 7; i >= 0; i--) begin
      sdio_i = hdr[i];
      wait_clk(HALF);
      if (sdio_oe || sdo_oe) oe_err++;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    for (int k = 0; k < nbits; k++) begin
      sdio_i = rw ? 1'b0 : wbytes[31-k];
      wait_clk(HALF);
      if (rw && k < counted) begin
        if (m3) begin
          if (!sdio_oe || sdo_oe) oe_err++;
          rbytes[31-k] = sdio_o;
        end else begin
          if (!sdo_oe || sdio_oe) oe_err++;
          rbytes[31-k] = sdo_o;
        end
      end else if (sdio_oe || sdo_oe) begin
        oe_err++;
      end
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    sen_n = 1'b1;
    wait_clk(6);
    if (sdio_oe || sdo_oe) oe_err++;
    wait_clk(HALF);
    if (!rw) begin
      for (int j = 0; j < (nbits / 8) && j <= int'(cnt); j++)
        model[step_addr(a, j)] = wbytes[31-8*j -: 8];
    end
  endtask

  task automatic par_read(input logic [4:0] a, output logic [7:0] d);
    par_addr = a;
    wait_clk(2);
    d = par_rdata;
  endtask

  task automatic par_write(input logic [4:0] a, input logic [7:0] d);
    par_addr = a; par_wdata = d; par_we = 1'b1;
    wait_clk(1);
    par_we = 1'b0;
    model[a] = d;
  endtask

  task automatic scan_all(output int mism);
    logic [7:0] d;
    mism = 0;
    for (int i = 0; i < 32; i++) begin
      par_read(5'(i), d);
      if (d !== model[i]) mism++;
    end
  endtask

  task automatic read_and_check(input string req, input logic [1:0] cnt,
                                input logic [4:0] a, input logic m3);
    logic [31:0] rb;
    int oe;
    spi_txn(1'b1, cnt, a, m3, 32'h0, 8 * (int'(cnt) + 1), rb, oe);
    check({req, " enables"}, 32'(oe), 32'd0);
    for (int j = 0; j <= int'(cnt); j++)
      check({req, " read byte"}, 32'(rb[31-8*j -: 8]), 32'(model[step_addr(a, j)]));
  endtask

  initial begin
    logic [31:0] rb;
    logic [7:0]  d;
    int oe, mism;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);

    // R1: reset state
    scan_all(mism);
    check("R1 registers zero", 32'(mism), 32'd0);
    check("R1 enables low", {30'd0, sdio_oe, sdo_oe}, 32'd0);

    // R2/R3: single-byte write, header bit order
    spi_txn(1'b0, 2'b00, 5'd5, 1'b0, 32'hA500_0000, 8, rb, oe);
    par_read(5'd5, d);
    check("R2 R3 single write", 32'(d), 32'hA5);
    check("R8 no enable during write", 32'(oe), 32'd0);

    // R4: four-byte write from address 1 wraps 1,0,31,30
    spi_txn(1'b0, 2'b11, 5'd1, 1'b1, 32'h1122_3344, 32, rb, oe);
    par_read(5'd31, d);
    check("R4 wrap byte 2", 32'(d), 32'h33);
    par_read(5'd30, d);
    check("R4 wrap byte 3", 32'(d), 32'h44);
    par_read(5'd0, d);
    check("R4 byte 1", 32'(d), 32'h22);

    // R5/R6: 3-wire burst read; R7: 4-wire burst read
    read_and_check("R5 R6 3-wire", 2'b11, 5'd1, 1'b1);
    read_and_check("R5 R7 4-wire", 2'b11, 5'd1, 1'b0);
    read_and_check("R5 R7 single 4-wire", 2'b00, 5'd5, 1'b0);

    // R3: early end keeps an incomplete byte out
    spi_txn(1'b0, 2'b00, 5'd9, 1'b0, 32'hFF00_0000, 5, rb, oe);
    par_read(5'd9, d);
    check("R3 abort single", 32'(d), 32'h00);
    spi_txn(1'b0, 2'b01, 5'd20, 1'b1, 32'h5AC3_0000, 12, rb, oe);
    par_read(5'd20, d);
    check("R3 abort first byte kept", 32'(d), 32'h5A);
    par_read(5'd19, d);
    check("R3 abort second byte dropped", 32'(d), 32'h00);

    // R9: extra clocks after the count is used up
    spi_txn(1'b0, 2'b00, 5'd12, 1'b0, 32'h3CFF_0000, 16, rb, oe);
    par_read(5'd12, d);
    check("R9 counted byte", 32'(d), 32'h3C);
    par_read(5'd11, d);
    check("R9 next address untouched", 32'(d), 32'h00);
    check("R8 R9 enables after count", 32'(oe), 32'd0);
    spi_txn(1'b1, 2'b00, 5'd12, 1'b1, 32'h0, 16, rb, oe);
    check("R8 R9 read extra clocks enables", 32'(oe), 32'd0);

    // R10: parallel write visible over serial read
    par_write(5'd17, 8'hE7);
    par_write(5'd16, 8'h81);
    par_read(5'd17, d);
    check("R10 parallel readback", 32'(d), 32'hE7);
    read_and_check("R10 serial sees parallel", 2'b01, 5'd17, 1'b1);

    // Random mix (fixed seed)
    void'($urandom(32'd4242));
    for (int t = 0; t < 40; t++) begin
      logic       rw, m3;
      logic [1:0] cnt;
      logic [4:0] a;
      logic [31:0] wb;
      rw  = 1'($urandom());
      m3  = 1'($urandom());
      cnt = 2'($urandom());
      a   = 5'($urandom());
      wb  = $urandom();
      if (rw) begin
        read_and_check(m3 ? "R6 random read" : "R7 random read", cnt, a, m3);
      end else begin
        spi_txn(1'b0, cnt, a, m3, wb, 8 * (int'(cnt) + 1), rb, oe);
        check("R8 random write enables", 32'(oe), 32'd0);
        scan_all(mism);
        check("R4 random write contents", 32'(mism), 32'd0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule